// File: doc/BRIEF.md
# Serial Link Status and Interrupt Register

This block is the status and interrupt register of a serial controller that runs either as a LIN node or as a plain UART. The protocol engine beside it sends one-cycle event pulses when a byte is received, when a response has been sent, and when a header has completed. In slave operation that last pulse means an identifier arrived; in master operation it means the header went out. The engine also sends per-cause error pulses, a busy level and the six-bit frame identifier. The block turns these into sticky flags that software reads and acknowledges through a small single-cycle register port. It decodes the four special identifiers 0x3C to 0x3F into a three-bit status field. It drives one level interrupt through a per-flag enable mask.

Software clears a flag by writing 1 to its bit; writing 0 leaves the bit alone. The error flag is not stored on its own. It is the OR of a separate error register, and acknowledging it wipes that whole register. In UART mode, software accesses to the data-register address also acknowledge traffic: a read clears the receive flag and a write clears the transmit flag. The data register itself lives elsewhere; this block only watches its address, and a read of it returns zero here. When a set event and a clear land in the same cycle, the set wins, so no event is lost.

Register port map (2-bit address): 0 status, 1 interrupt enable, 2 error causes, 3 data (side effects only).

Top module: `lin_stat_irq`

## Requirements
- R1: After reset, the status, enable and error registers all read 0 and irq is 0.
- R2: On a header-done pulse the status field in bits 7:5 loads 3'b1nn when frame_id is 0x3C+nn (0x3C..0x3F), and 3'b000 for any other identifier. It holds its value until the next header-done pulse.
- R3: Writes to the status address leave bits 7:5 (identifier status) and bit 4 (busy) unchanged.
- R4: Status bits 2 (identifier OK), 1 (transmit OK) and 0 (receive OK) are set by their event pulses and cleared by writing 1 to that bit. Writing 0 to a bit has no effect on it.
- R5: Status bit 4 shows the busy input as it was one clock earlier.
- R6: The error address holds an 8-bit register in which each error-pulse bit sets the matching bit. Status bit 3 reads as the OR of that register.
- R7: Writing 1 to status bit 3 clears every bit of the error register.
- R8: When uart_mode is 1, a write to the data address clears the transmit OK flag. When uart_mode is 0, the same write leaves the flag unchanged.
- R9: When uart_mode is 1, a read (bus_rd) of the data address clears the receive OK flag. When uart_mode is 0, the same read leaves the flag unchanged.
- R10: irq is a register. One cycle after any status bit 3..0 is 1 while its enable bit is 1, irq is 1; otherwise it is 0. The enable mask is: bit 0 receive, bit 1 transmit, bit 2 identifier, bit 3 error.
- R11: When an event pulse and any clear of the same flag happen in the same cycle, the flag ends up set. Error bits pulsed during an error wipe also remain.
- R12: The enable address stores bits 3:0 of a write and reads bits 7:4 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_rd | input | 1 | Read strobe, single cycle (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| uart_mode | input | 1 | 1 selects UART mode data-access clears |
| busy_in | input | 1 | Engine is receiving or transmitting |
| ev_rx_done | input | 1 | Receive complete pulse |
| ev_tx_done | input | 1 | Response transmit complete pulse |
| ev_hdr_done | input | 1 | Identifier received / header sent pulse |
| err_set | input | 8 | Error cause pulses, one bit per cause |
| frame_id | input | 6 | Identifier of the current frame |
| irq | output | 1 | Registered interrupt level |

## Verification
The hardest situation to reach is a collision: an event pulse in the same cycle as a write-1 clear or a data-address side-effect clear. It is worst of all when it also meets an error wipe while new cause bits arrive. Purely random stimulus rarely lines these up, so the bench drives them as directed cases. Its random phase then raises the event and strobe densities, which makes overlaps of pulses, clears and mode changes common. Every cycle of that phase is compared against a cycle-accurate model in the bench.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ID_W   = 6;
  localparam int unsigned IDST_W = 3;

  localparam logic [1:0] ADR_STAT = 2'd0;
  localparam logic [1:0] ADR_EN   = 2'd1;
  localparam logic [1:0] ADR_ERR  = 2'd2;
  localparam logic [1:0] ADR_DATA = 2'd3;

  // flag vector order, shared by enables and status low bits
  typedef enum int unsigned {
    FL_RX  = 0,
    FL_TX  = 1,
    FL_ID  = 2,
    FL_ERR = 3
  } flag_idx_e;

  localparam int unsigned NFLAG = 4;

  // special identifiers 0x3C..0x3F map to 1nn, all others to 000
  function automatic logic [IDST_W-1:0] id_status(input logic [ID_W-1:0] id);
    logic special;
    special = (id[ID_W-1:2] == {(ID_W-2){1'b1}});
    return special ? {1'b1, id[1:0]} : '0;
  endfunction

  function automatic logic irq_level(input logic [NFLAG-1:0] flags,
                                     input logic [NFLAG-1:0] en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/lsi_flag.sv
module lsi_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set_i | (q & ~clr_i);
  end

  assign q_o = q;

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/lsi_err_bank.sv
module lsi_err_bank #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err_set_i,
  input  logic             wipe_i,
  output logic [ERR_W-1:0] err_q_o,
  output logic             err_flag_o
);
  logic [ERR_W-1:0] err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_set_i | (wipe_i ? '0 : err_q);
  end

  assign err_q_o    = err_q;
  assign err_flag_o = |err_q;

  a_r6_cause_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set_i) |=> err_flag_o);

  a_r7_wipe_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_i && err_set_i == '0) |=> (err_q_o == '0));
endmodule

// File: rtl/lsi_id_track.sv
module lsi_id_track
  import lin_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_ev_i,
  input  logic [ID_W-1:0]   frame_id_i,
  output logic [IDST_W-1:0] idst_o
);
  logic [IDST_W-1:0] idst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idst_q <= '0;
    else if (hdr_ev_i) idst_q <= id_status(frame_id_i);
  end

  assign idst_o = idst_q;

  a_r2_special_id: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_ev_i && frame_id_i[ID_W-1:2] == 4'hF) |=> idst_o[IDST_W-1]);

  a_r2_plain_id: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_ev_i && frame_id_i[ID_W-1:2] != 4'hF) |=> (idst_o == '0));
endmodule

// File: rtl/lin_stat_irq.sv
module lin_stat_irq
  import lin_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              uart_mode,
  input  logic              busy_in,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_hdr_done,
  input  logic [ERR_W-1:0]  err_set,
  input  logic [ID_W-1:0]   frame_id,
  output logic              irq
);
  localparam int unsigned NCELL = 3; // rx, tx, id held in flag cells

  // decoded bus events, named for the assertions
  logic wr_stat, wr_en, wr_data, rd_data;
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
  assign wr_en   = bus_wr && (bus_addr == ADDR_W'(ADR_EN));
  assign wr_data = bus_wr && (bus_addr == ADDR_W'(ADR_DATA));
  assign rd_data = bus_rd && (bus_addr == ADDR_W'(ADR_DATA));

  logic [NFLAG-1:0] w1c;
  assign w1c = wr_stat ? bus_wdata[NFLAG-1:0] : '0;

  logic uart_rx_clr, uart_tx_clr;
  assign uart_rx_clr = uart_mode && rd_data;
  assign uart_tx_clr = uart_mode && wr_data;

  // flag cells
  logic [NCELL-1:0] cell_set, cell_clr, cell_q;
  assign cell_set = {ev_hdr_done, ev_tx_done, ev_rx_done};
  assign cell_clr = {w1c[FL_ID], w1c[FL_TX] | uart_tx_clr, w1c[FL_RX] | uart_rx_clr};

  for (genvar g = 0; g < NCELL; g++) begin : g_flag
    lsi_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (cell_set[g]),
      .clr_i (cell_clr[g]),
      .q_o   (cell_q[g])
    );
  end

  logic [ERR_W-1:0] err_q;
  logic             err_flag;
  lsi_err_bank #(.ERR_W(ERR_W)) u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_set_i  (err_set),
    .wipe_i     (w1c[FL_ERR]),
    .err_q_o    (err_q),
    .err_flag_o (err_flag)
  );

  logic [IDST_W-1:0] idst;
  lsi_id_track u_id (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_ev_i   (ev_hdr_done),
    .frame_id_i (frame_id),
    .idst_o     (idst)
  );

  logic             busy_q;
  logic [NFLAG-1:0] en_q;
  logic             irq_q;
  logic [NFLAG-1:0] flag_vec;
  assign flag_vec = {err_flag, cell_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_in;
      if (wr_en) en_q <= bus_wdata[NFLAG-1:0];
      irq_q  <= irq_level(flag_vec, en_q);
    end
  end

  assign irq = irq_q;

  logic [DATA_W-1:0] stat_word;
  assign stat_word = {idst, busy_q, flag_vec};

  always_comb begin
    case (bus_addr)
      ADDR_W'(ADR_STAT): bus_rdata = stat_word;
      ADDR_W'(ADR_EN):   bus_rdata = {{(DATA_W-NFLAG){1'b0}}, en_q};
      ADDR_W'(ADR_ERR):  bus_rdata = DATA_W'(err_q);
      default:           bus_rdata = '0;
    endcase
  end

  a_r10_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_vec & en_q)) |=> irq);

  a_r10_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_vec & en_q)) |=> !irq);

  a_r3_idst_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !ev_hdr_done) |=> $stable(idst));
endmodule

// File: tb/tb_lin_stat_irq.sv
module tb_lin_stat_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       uart_mode = 1'b0, busy_in = 1'b0;
  logic       ev_rx_done = 1'b0, ev_tx_done = 1'b0, ev_hdr_done = 1'b0;
  logic [7:0] err_set = '0;
  logic [5:0] frame_id = '0;
  logic       irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lin_stat_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uart_mode(uart_mode), .busy_in(busy_in),
    .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done), .ev_hdr_done(ev_hdr_done),
    .err_set(err_set), .frame_id(frame_id), .irq(irq)
  );

  // bench model
  logic m_rx, m_tx, m_id, m_busy, m_irq;
  logic [7:0] m_err;
  logic [2:0] m_idst;
  logic [3:0] m_en;

  function automatic logic [2:0] ref_idst(input logic [5:0] id);
    case (id)
      6'd60: return 3'b100;
      6'd61: return 3'b101;
      6'd62: return 3'b110;
      6'd63: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [7:0] ref_read(input logic [1:0] a);
    case (a)
      2'd0: return {m_idst, m_busy, (m_err != 0), m_id, m_tx, m_rx};
      2'd1: return {4'b0, m_en};
      2'd2: return m_err;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_rx = 0; m_tx = 0; m_id = 0; m_busy = 0; m_irq = 0;
    m_err = 0; m_idst = 0; m_en = 0;
  endtask

  task automatic tick();
    logic [3:0] clr;
    logic n_rx, n_tx, n_id, n_busy, n_irq;
    logic [7:0] n_err;
    logic [2:0] n_idst;
    logic [3:0] n_en;
    clr    = (bus_wr && bus_addr == 2'd0) ? bus_wdata[3:0] : 4'h0;
    n_rx   = ev_rx_done || (m_rx && !(clr[0] || (uart_mode && bus_rd && bus_addr == 2'd3)));
    n_tx   = ev_tx_done || (m_tx && !(clr[1] || (uart_mode && bus_wr && bus_addr == 2'd3)));
    n_id   = ev_hdr_done || (m_id && !clr[2]);
    n_err  = err_set | (clr[3] ? 8'h00 : m_err);
    n_idst = ev_hdr_done ? ref_idst(frame_id) : m_idst;
    n_busy = busy_in;
    n_en   = (bus_wr && bus_addr == 2'd1) ? bus_wdata[3:0] : m_en;
    n_irq  = (m_rx && m_en[0]) || (m_tx && m_en[1]) || (m_id && m_en[2]) || ((m_err != 0) && m_en[3]);
    @(posedge clk);
    m_rx = n_rx; m_tx = n_tx; m_id = n_id; m_err = n_err;
    m_idst = n_idst; m_busy = n_busy; m_en = n_en; m_irq = n_irq;
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; ev_rx_done = 0; ev_tx_done = 0; ev_hdr_done = 0; err_set = 0;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  // read an address after one idle cycle and compare with the model
  task automatic rd_chk(input string tag, input logic [1:0] a);
    idle(); bus_addr = a;
    tick();
    chk(tag, bus_rdata, ref_read(a));
  endtask

  task automatic irq_chk(input string tag);
    chk(tag, {7'b0, irq}, {7'b0, m_irq});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    idle(); bus_addr = a; bus_wr = 1; bus_wdata = d;
    tick(); idle();
  endtask

  task automatic ev(input logic rx, input logic tx, input logic hd, input logic [7:0] es,
                    input logic [5:0] fid);
    idle(); ev_rx_done = rx; ev_tx_done = tx; ev_hdr_done = hd; err_set = es; frame_id = fid;
    tick(); idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    model_reset();
    @(negedge clk); @(negedge clk);
    // R1 reset values
    chk("R1 status", bus_rdata, 8'h00);
    irq_chk("R1 irq");
    rst_n = 1;
    rd_chk("R1 enable", 2'd1);
    rd_chk("R1 error", 2'd2);

    // R12 enable register width
    wr(2'd1, 8'hFF);
    rd_chk("R12 enable upper zero", 2'd1);
    wr(2'd1, 8'h00);

    // R2 identifier status decode
    ev(0, 0, 1, 8'h00, 6'h3D);
    rd_chk("R2 id 0x3D", 2'd0);
    ev(0, 0, 1, 8'h00, 6'h3B);
    rd_chk("R2 id 0x3B", 2'd0);
    ev(0, 0, 1, 8'h00, 6'h3F);
    frame_id = 6'h00;
    rd_chk("R2 id 0x3F held", 2'd0);

    // R5 busy follows input
    busy_in = 1;
    rd_chk("R5 busy high", 2'd0);

    // R3 read-only upper bits (0xF0 touches no flag)
    wr(2'd0, 8'hF0);
    rd_chk("R3 upper bits unchanged", 2'd0);
    busy_in = 0;
    wr(2'd0, 8'h04);
    rd_chk("R5 busy low", 2'd0);

    // R4 selective write-one-to-clear
    ev(1, 1, 1, 8'h00, 6'h10);
    wr(2'd0, 8'h02);
    rd_chk("R4 only tx cleared", 2'd0);
    wr(2'd0, 8'h00);
    rd_chk("R4 zero write no effect", 2'd0);

    // R6 error accumulation
    ev(0, 0, 0, 8'h10, 6'h00);
    ev(0, 0, 0, 8'h02, 6'h00);
    rd_chk("R6 error register", 2'd2);
    rd_chk("R6 error flag", 2'd0);

    // R7 wipe
    wr(2'd0, 8'h08);
    rd_chk("R7 error wiped", 2'd2);
    rd_chk("R7 flag low", 2'd0);

    // R8 data write clears tx only in UART mode
    ev(0, 1, 0, 8'h00, 6'h00);
    uart_mode = 0; wr(2'd3, 8'h55);
    rd_chk("R8 LIN mode tx kept", 2'd0);
    uart_mode = 1; wr(2'd3, 8'h55);
    rd_chk("R8 UART mode tx cleared", 2'd0);

    // R9 data read clears rx only in UART mode
    ev(1, 0, 0, 8'h00, 6'h00);
    uart_mode = 0; idle(); bus_addr = 2'd3; bus_rd = 1; tick(); idle();
    rd_chk("R9 LIN mode rx kept", 2'd0);
    uart_mode = 1; idle(); bus_addr = 2'd3; bus_rd = 1; tick(); idle();
    rd_chk("R9 UART mode rx cleared", 2'd0);

    // R11 collisions
    idle(); bus_addr = 2'd0; bus_wr = 1; bus_wdata = 8'h0F;
    ev_tx_done = 1; err_set = 8'h40; tick(); idle();
    rd_chk("R11 tx set wins", 2'd0);
    rd_chk("R11 new error kept", 2'd2);
    idle(); bus_addr = 2'd3; bus_wr = 1; ev_tx_done = 1; tick(); idle();
    rd_chk("R11 tx set beats data write", 2'd0);

    // R10 interrupt timing
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h01);
    rd_chk("R10 flags clear", 2'd0);
    irq_chk("R10 irq low");
    ev(1, 0, 0, 8'h00, 6'h00);
    irq_chk("R10 irq one cycle late");
    idle(); tick();
    irq_chk("R10 irq high");
    wr(2'd1, 8'h02);
    idle(); tick();
    irq_chk("R10 masked");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom(i == 0 ? 32'd2024 : 32'd0);
      if (i == 0) r = $urandom;
      idle();
      bus_addr    = r[1:0];
      bus_wr      = r[2] & r[3];
      bus_rd      = r[4];
      bus_wdata   = $urandom;
      uart_mode   = r[5];
      busy_in     = r[6];
      ev_rx_done  = r[7] & r[8];
      ev_tx_done  = r[9] & r[10];
      ev_hdr_done = r[11] & r[12];
      err_set     = (r[13] & r[14]) ? 8'($urandom) : 8'h00;
      frame_id    = r[15] ? {4'hF, r[17:16]} : r[21:16];
      tick();
      case (bus_addr)
        2'd0: chk("R4/R11 random status", bus_rdata, ref_read(bus_addr));
        2'd1: chk("R12 random enable", bus_rdata, ref_read(bus_addr));
        2'd2: chk("R6/R7 random error", bus_rdata, ref_read(bus_addr));
        default: chk("R9 random data", bus_rdata, ref_read(bus_addr));
      endcase
      irq_chk("R10 random irq");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule